// File: doc/BRIEF.md
# Sixteen-Bit Target and Wrap Timer Bank

This block holds a small bank of 16-bit up-counting timer channels behind a plain register bus. Each channel has a count, a mode and a target register. A channel counts system-clock-enable pulses, or a slowed version of them. It raises two kinds of terminal event: the count reaching the target value, and the count wrapping from 0xFFFF back to 0. Mode bit 3 decides whether a target hit returns the count to 0 or lets it keep running. Mode bits 4 and 5 choose which event raises an interrupt pulse. Mode bit 6 chooses between a single interrupt and repeated interrupts.

Channel 0 can divide its clock enable by five with mode bit 8. Channel 1 can count an external line tick instead, also with mode bit 8. Channel 2 can divide by eight with mode bit 9 and can be halted with mode bit 0. Sticky status bits record the events: bit 11 for a target hit, bit 12 for a wrap, and bit 10 for either event. Reading the mode register clears bits 11 and 12. Each channel's interrupt pulse lands on bit 4 plus the channel number of the interrupt word.

Each channel's interrupt gating is a two-state machine, and its states are ST_ARMED and ST_SPENT. The machine moves from ST_ARMED to ST_SPENT when an interrupt fires and repeat mode is off. ST_SPENT holds until the next mode write. A mode write returns either state to ST_ARMED. Every other cycle leaves the state unchanged.

Top module: `prog_timer`

## Requirements
- R1: After reset, every count, mode and target register reads 0 and `irq_word` is 0.
- R2: The register is chosen by `bus_reg`: 0 is count, 1 is mode and 2 is target. A write sets the chosen register of channel `bus_ch` on the clock edge. A read returns the value held at the edge where `rd_en` is high, on `rd_data` from the next cycle, and `rd_data` holds while `rd_en` is low.
- R3: With mode bit 3 clear, the count goes up by 1 per tick, passes the target, and wraps from 0xFFFF to 0.
- R4: With mode bit 3 set, a tick that would bring the count to the target loads 0 instead.
- R5: Status bit 11 sets on a target hit and bit 12 sets on a wrap. Bit 10 sets on either event. Bits 13 to 15 of the mode register always read 0.
- R6: A mode read returns the value as it was, and then clears bits 11 and 12 while keeping bit 10. An event in the same cycle as the read stays recorded.
- R7: An event whose interrupt is enabled, by bit 4 for a target hit or bit 5 for a wrap, produces a one-cycle pulse on `irq_word` bit 4 plus the channel number. The pulse comes on the same edge that sets the status bit.
- R8: With bit 6 clear, only the first qualifying event after a mode write gives a pulse. A count write does not re-arm the interrupt, and a mode write does.
- R9: With bit 6 set, every qualifying event gives a pulse.
- R10: A mode write stores bits 0 to 9, clears bits 10 to 15, forces the count to 0, and takes precedence over a tick in the same cycle.
- R11: A target write changes the compare value and leaves the count unchanged.
- R12: No count changes while `clk_en` is low, except through bus writes.
- R13: The prescale options are as follows. On channel 0, bit 8 gives one tick per five clock enables. On channel 1, bit 8 gives one tick per `line_tick` cycle. On channel 2, bit 9 gives one tick per eight clock enables and bit 0 stops counting. A count or mode write restarts the divider.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Count enable, one pulse per base tick |
| line_tick | input | 1 | External tick source for channel 1 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| bus_ch | input | 2 | Channel select |
| bus_reg | input | 2 | Register select: 0 count, 1 mode, 2 target |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data, one cycle after `rd_en` |
| irq_word | output | 16 | Interrupt pulses, channel n on bit 4+n |

## Verification
A count moves on the edge that consumes a qualifying tick. The interrupt pulse and the status bit both appear on that same edge, so both are visible during the following low clock phase. Read data appears one cycle after the `rd_en` edge. The bench drives its inputs on falling edges and samples on falling edges. It keeps `clk_en` low during every bus access, so a value read back depends only on the number of enabled cycles it has issued. Interrupt pulses are counted once per low phase, which makes a pulse that lasts two cycles visible as a miscount.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DW = 16;

    localparam logic [1:0] REG_CNT = 2'd0;
    localparam logic [1:0] REG_MODE = 2'd1;
    localparam logic [1:0] REG_TGT = 2'd2;

    localparam int B_STOP = 0;
    localparam int B_TGT_RST = 3;
    localparam int B_IRQ_TGT = 4;
    localparam int B_IRQ_OVF = 5;
    localparam int B_RPT = 6;
    localparam int B_HIT_ANY = 10;
    localparam int B_HIT_TGT = 11;
    localparam int B_HIT_OVF = 12;
    localparam int STORED_BITS = 10;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_SPENT = 1'b1
    } irq_state_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SLOW_DIV = 1,
    parameter bit USE_LINE = 1'b0,
    localparam int DCW = $clog2(SLOW_DIV > 1 ? SLOW_DIV : 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic line_tick,
    input  logic restart,
    input  logic slow,
    input  logic stop,
    output logic tick
);
    logic [DCW-1:0] div_q;
    logic           div_hit;
    logic           run;

    assign run     = clk_en && !stop;
    assign div_hit = (div_q == DCW'(SLOW_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (run && slow && !USE_LINE) begin
            div_q <= div_hit ? '0 : div_q + 1'b1;
        end
    end

    assign tick = run && (!slow || (USE_LINE ? line_tick : div_hit));

    // R13: a divided tick is never followed by another in the next cycle
    a_r13_divider_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && slow && !USE_LINE && (SLOW_DIV > 1) && !restart) |=> !tick);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int SLOW_BIT = 8,
    parameter int SLOW_DIV = 1,
    parameter bit USE_LINE = 1'b0,
    parameter bit HAS_STOP = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          line_tick,
    input  logic          wr_count,
    input  logic          wr_mode,
    input  logic          wr_target,
    input  logic          rd_mode,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] count_o,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] target_o,
    output logic          irq_o
);
    logic [DW-1:0] cnt_q, mode_q, tgt_q;
    logic [DW-1:0] cnt_inc;
    logic          tick, load, stop;
    logic          ev_tgt, ev_ovf, fire;
    irq_state_e    state_q, state_d;

    assign stop = HAS_STOP ? mode_q[B_STOP] : 1'b0;
    assign load = wr_count || wr_mode;

    tmr_prescale #(.SLOW_DIV(SLOW_DIV), .USE_LINE(USE_LINE)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .line_tick(line_tick),
        .restart  (load),
        .slow     (mode_q[SLOW_BIT]),
        .stop     (stop),
        .tick     (tick)
    );

    assign cnt_inc = cnt_q + 16'd1;
    assign ev_tgt  = tick && !load && (cnt_inc == tgt_q);
    assign ev_ovf  = tick && !load && (cnt_q == 16'hFFFF);
    assign fire    = ((ev_tgt && mode_q[B_IRQ_TGT]) || (ev_ovf && mode_q[B_IRQ_OVF]))
                     && (state_q == ST_ARMED || mode_q[B_RPT]);

    // counter and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgt_q <= '0;
        end else begin
            if (wr_target) tgt_q <= wdata;
            if (wr_mode) begin
                cnt_q <= '0;
            end else if (wr_count) begin
                cnt_q <= wdata;
            end else if (tick) begin
                cnt_q <= (ev_tgt && mode_q[B_TGT_RST]) ? '0 : cnt_inc;
            end
        end
    end

    // mode and sticky status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= {{(DW-STORED_BITS){1'b0}}, wdata[STORED_BITS-1:0]};
        end else begin
            if (rd_mode) begin
                mode_q[B_HIT_TGT] <= 1'b0;
                mode_q[B_HIT_OVF] <= 1'b0;
            end
            if (ev_tgt) mode_q[B_HIT_TGT] <= 1'b1;
            if (ev_ovf) mode_q[B_HIT_OVF] <= 1'b1;
            if (ev_tgt || ev_ovf) mode_q[B_HIT_ANY] <= 1'b1;
        end
    end

    // interrupt gating state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (fire && !mode_q[B_RPT]) state_d = ST_SPENT;
            ST_SPENT: state_d = ST_SPENT;
        endcase
        if (wr_mode) state_d = ST_ARMED;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= fire;
    end

    assign count_o  = cnt_q;
    assign mode_o   = mode_q;
    assign target_o = tgt_q;

    // R4: a target hit in reset mode leaves the count at zero
    a_r4_target_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tgt && mode_q[B_TGT_RST]) |=> (cnt_q == '0));
    // R8: once spent without repeat, no pulse until a mode write
    a_r8_oneshot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPENT && !mode_q[B_RPT]) |=> !irq_o);
    // R10: a mode write restarts the count and re-arms
    a_r10_mode_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (cnt_q == '0 && state_q == ST_ARMED));
    // R12: without clock enable the count moves only by writes
    a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !load) |=> $stable(cnt_q));
    // R6: a mode read with no event leaves both hit bits clear
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode && !wr_mode && !tick) |=> (mode_q[B_HIT_OVF:B_HIT_TGT] == 2'b00));
    // R7: the pulse coincides with a hit status bit being set
    a_r7_pulse_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mode_q[B_HIT_TGT] || mode_q[B_HIT_OVF]));
endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int PIX_DIV = 5,
    parameter int EIGHTH_DIV = 8,
    parameter int IRQ_BASE = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CHN = 2 ** CHW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clk_en,
    input  logic           line_tick,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [CHW-1:0] bus_ch,
    input  logic [1:0]     bus_reg,
    input  logic [DW-1:0]  wr_data,
    output logic [DW-1:0]  rd_data,
    output logic [DW-1:0]  irq_word
);
    logic [DW-1:0] cnt_a [CHN];
    logic [DW-1:0] mode_a [CHN];
    logic [DW-1:0] tgt_a [CHN];
    logic [CHN-1:0] irq_a;
    logic [DW-1:0] rd_sel;

    for (genvar i = 0; i < CHN; i++) begin : g_ch
        if (i < NCH) begin : g_live
            logic hit;
            assign hit = (bus_ch == CHW'(i));
            tmr_channel #(
                .SLOW_BIT((i == 2) ? 9 : 8),
                .SLOW_DIV((i == 0) ? PIX_DIV : ((i == 2) ? EIGHTH_DIV : 1)),
                .USE_LINE(i == 1),
                .HAS_STOP(i == 2)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .clk_en   (clk_en),
                .line_tick(line_tick),
                .wr_count (wr_en && hit && bus_reg == REG_CNT),
                .wr_mode  (wr_en && hit && bus_reg == REG_MODE),
                .wr_target(wr_en && hit && bus_reg == REG_TGT),
                .rd_mode  (rd_en && hit && bus_reg == REG_MODE),
                .wdata    (wr_data),
                .count_o  (cnt_a[i]),
                .mode_o   (mode_a[i]),
                .target_o (tgt_a[i]),
                .irq_o    (irq_a[i])
            );
        end else begin : g_void
            assign cnt_a[i]  = '0;
            assign mode_a[i] = '0;
            assign tgt_a[i]  = '0;
            assign irq_a[i]  = 1'b0;
        end
    end

    always_comb begin
        unique case (bus_reg)
            REG_CNT:  rd_sel = cnt_a[bus_ch];
            REG_MODE: rd_sel = mode_a[bus_ch];
            REG_TGT:  rd_sel = tgt_a[bus_ch];
            default:  rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_sel;
    end

    always_comb begin
        irq_word = '0;
        for (int i = 0; i < NCH; i++) irq_word[IRQ_BASE + i] = irq_a[i];
    end

    // R5: mode reads never show the upper three bits
    a_r5_mode_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_reg == REG_MODE) |=> (rd_data[15:13] == 3'b000));
    // R2: read data holds between reads
    a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/prog_timer_bench.sv
module prog_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        line_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  bus_ch = '0;
    logic [1:0]  bus_reg = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [15:0] irq_word;

    int n_run = 0;
    int n_fail = 0;
    int p4 = 0, p5 = 0, p6 = 0, p_other = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prog_timer u_prog_timer (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .line_tick(line_tick),
        .wr_en(wr_en), .rd_en(rd_en), .bus_ch(bus_ch), .bus_reg(bus_reg),
        .wr_data(wr_data), .rd_data(rd_data), .irq_word(irq_word)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            p4 += int'(irq_word[4]);
            p5 += int'(irq_word[5]);
            p6 += int'(irq_word[6]);
            p_other += $countones(irq_word & ~16'h0070);
        end
    end

    // rows: mode, target, start count, steps, expected count, expected mode read
    localparam logic [95:0] VEC [7] = '{
        {16'h0000, 16'h0010, 16'h0005, 16'd3, 16'h0008, 16'h0000},
        {16'h0008, 16'h0010, 16'h000E, 16'd3, 16'h0001, 16'h0C08},
        {16'h0000, 16'h0010, 16'h000E, 16'd3, 16'h0011, 16'h0C00},
        {16'h0000, 16'h1000, 16'hFFFE, 16'd3, 16'h0001, 16'h1400},
        {16'h0008, 16'h0000, 16'hFFFF, 16'd1, 16'h0000, 16'h1C08},
        {16'h0030, 16'h0003, 16'h0000, 16'd2, 16'h0002, 16'h0030},
        {16'hEAC4, 16'h0100, 16'h0020, 16'd4, 16'h0024, 16'h02C4}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] ch, input logic [1:0] rg, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; bus_ch = ch; bus_reg = rg; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] ch, input logic [1:0] rg, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; bus_ch = ch; bus_reg = rg;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic step(input int n);
        if (n > 0) begin
            @(negedge clk);
            clk_en = 1'b1;
            repeat (n) @(negedge clk);
            clk_en = 1'b0;
        end
    endtask

    initial begin
        logic [15:0] v;
        int b4, b5, b6;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_word", irq_word, 16'h0000);
        rd(2'd0, 2'd0, v); chk("R1 count", v, 16'h0000);
        rd(2'd0, 2'd1, v); chk("R1 mode", v, 16'h0000);
        rd(2'd0, 2'd2, v); chk("R1 target", v, 16'h0000);

        // table walk on channel 0: R3 R4 R5 R10
        b4 = p4;
        for (int k = 0; k < 7; k++) begin
            wr(2'd0, 2'd1, VEC[k][95:80]);
            wr(2'd0, 2'd2, VEC[k][79:64]);
            wr(2'd0, 2'd0, VEC[k][63:48]);
            step(int'(VEC[k][47:32]));
            rd(2'd0, 2'd0, v); chk($sformatf("R3/R4 row %0d count", k), v, VEC[k][31:16]);
            rd(2'd0, 2'd1, v); chk($sformatf("R5/R10 row %0d mode", k), v, VEC[k][15:0]);
        end
        chk("R7 no pulse without event", 16'(p4 - b4), 16'd0);

        // R6 clear on read, bit 10 kept
        wr(2'd0, 2'd1, 16'h0000);
        wr(2'd0, 2'd2, 16'h0002);
        step(2);
        rd(2'd0, 2'd1, v); chk("R6 first read", v, 16'h0C00);
        rd(2'd0, 2'd1, v); chk("R6 second read", v, 16'h0400);

        // R6 event in the same cycle as the read
        wr(2'd0, 2'd1, 16'h0008);
        wr(2'd0, 2'd2, 16'h0001);
        @(negedge clk);
        rd_en = 1'b1; bus_ch = 2'd0; bus_reg = 2'd1; clk_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; clk_en = 1'b0;
        chk("R6 coincident read old value", rd_data, 16'h0008);
        rd(2'd0, 2'd1, v); chk("R6 coincident event kept", v, 16'h0C08);

        // R11 target write keeps the count
        wr(2'd0, 2'd1, 16'h0000);
        wr(2'd0, 2'd0, 16'h0040);
        wr(2'd0, 2'd2, 16'h0050);
        rd(2'd0, 2'd0, v); chk("R11 count kept", v, 16'h0040);
        rd(2'd0, 2'd2, v); chk("R11 target read back", v, 16'h0050);

        // R12 no counting without clk_en
        repeat (10) @(negedge clk);
        rd(2'd0, 2'd0, v); chk("R12 idle count", v, 16'h0040);

        // R7 R8 one-shot target interrupt on channel 1
        b4 = p4; b5 = p5; b6 = p6;
        wr(2'd1, 2'd1, 16'h0010);
        wr(2'd1, 2'd2, 16'h0003);
        step(2);
        chk("R7 no pulse before hit", {15'd0, irq_word[5]}, 16'd0);
        step(1);
        chk("R7 pulse on hit edge", {15'd0, irq_word[5]}, 16'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", {15'd0, irq_word[5]}, 16'd0);
        rd(2'd1, 2'd1, v); chk("R7 status with pulse", v, 16'h0C10);
        wr(2'd1, 2'd0, 16'h0000);
        step(3);
        @(negedge clk);
        chk("R8 count write does not re-arm", 16'(p5 - b5), 16'd1);
        wr(2'd1, 2'd1, 16'h0010);
        step(3);
        @(negedge clk);
        chk("R8 mode write re-arms", 16'(p5 - b5), 16'd2);

        // R9 repeat with target reset
        wr(2'd1, 2'd1, 16'h0058);
        wr(2'd1, 2'd2, 16'h0002);
        step(6);
        @(negedge clk);
        chk("R9 repeated pulses", 16'(p5 - b5), 16'd5);
        chk("R7 lane isolation ch0", 16'(p4 - b4), 16'd0);

        // R7 overflow interrupt on channel 2, lane bit 6
        wr(2'd2, 2'd1, 16'h0020);
        wr(2'd2, 2'd0, 16'hFFFF);
        step(1);
        chk("R7 wrap pulse bit 6", {15'd0, irq_word[6]}, 16'd1);
        @(negedge clk);
        chk("R7 wrap pulse count", 16'(p6 - b6), 16'd1);
        rd(2'd2, 2'd1, v); chk("R5 wrap status", v, 16'h1C20);
        rd(2'd2, 2'd0, v); chk("R3 wrap to zero", v, 16'h0000);

        // R13 prescale variants
        wr(2'd0, 2'd1, 16'h0100);
        step(14);
        rd(2'd0, 2'd0, v); chk("R13 divide by five", v, 16'h0002);
        wr(2'd2, 2'd1, 16'h0200);
        step(16);
        rd(2'd2, 2'd0, v); chk("R13 divide by eight", v, 16'h0002);
        wr(2'd2, 2'd1, 16'h0001);
        wr(2'd2, 2'd0, 16'h0007);
        step(20);
        rd(2'd2, 2'd0, v); chk("R13 stopped", v, 16'h0007);
        wr(2'd1, 2'd1, 16'h0100);
        step(10);
        rd(2'd1, 2'd0, v); chk("R13 line tick idle", v, 16'h0000);
        @(negedge clk);
        clk_en = 1'b1; line_tick = 1'b1;
        repeat (3) @(negedge clk);
        clk_en = 1'b0; line_tick = 1'b0;
        rd(2'd1, 2'd0, v); chk("R13 line tick counted", v, 16'h0003);

        chk("R7 no stray lanes", 16'(p_other), 16'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule